// File: doc/BRIEF.md
# Power-of-Two Region Window Splitter

This engine covers one contiguous address region with the fewest naturally aligned, power-of-two sized translation windows. The caller gives a physical start, the bus address it maps to, a byte size and the first free window number. The engine then produces one window description per clock: a match address with an enable flag, a remap address, and an address mask. It stops when the region is fully covered, when the window budget is spent, or when the next window would fall below the minimum window size.

Several regions share one window budget. The caller passes the index returned by the previous region as the starting index of the next one. If a region cannot be fully covered, the engine returns an invalid index marker and sets a failure latch. From then on it refuses every later region until reset. Writing the window descriptions into a translator is left to the caller.

Top module: `region_window_splitter`

## Requirements
- R1: Each window size is the smaller of two values: the largest power of two not above the remaining size, and the lowest set bit of the current physical start. A physical start of zero places no alignment limit on the size.
- R2: If the computed window size is below 64 KiB (0x10000), the engine emits no window and stops splitting.
- R3: The window mask equals the bitwise complement of (size - 1) with bits 15:0 forced to zero. The remap output equals the current bus start.
- R4: After each window, the physical start and the bus start both grow by the window size and the remaining size shrinks by it. The window number of consecutive windows counts up from the starting index given with the request.
- R5: No window is numbered 8 or above. Splitting stops once the index reaches 8.
- R6: If size remains when splitting stops, done reports the index 4'hF with err_o high, and fail_o goes high and stays high until reset.
- R7: A request made while fail_o is high, or with starting index 4'hF, completes with done_o, err_o and index 4'hF one cycle after the accepting edge. No window is emitted.
- R8: win_match_o is the current physical start with bit 0 set as the window enable flag.
- R9: For an accepted request with N windows, win_valid_o is high in the N cycles after the 1st through Nth edges following the accepting edge, one window per cycle. done_o pulses after edge N+1. On success, done_idx_o holds the next free window index, so a zero-size region finishes after one edge with no windows.
- R10: After reset, busy_o, win_valid_o, done_o, err_o and fail_o are low, and done_idx_o is zero.
- R11: start_i is ignored while busy_o is high, and the region being split is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted while idle |
| phys_i | input | 40 | Physical start of the region |
| bus_i | input | 40 | Bus address of the region start |
| size_i | input | 40 | Region size in bytes |
| win_idx_i | input | 4 | First free window index (4'hF = invalid) |
| busy_o | output | 1 | Region being split |
| win_valid_o | output | 1 | Window tuple valid this cycle |
| win_num_o | output | 4 | Index of the emitted window |
| win_match_o | output | 40 | Match address, bit 0 = enable |
| win_remap_o | output | 40 | Remap (bus) address |
| win_mask_o | output | 40 | Address mask |
| done_o | output | 1 | Region finished pulse |
| done_idx_o | output | 4 | Next free index, or 4'hF on failure |
| err_o | output | 1 | Region not covered, valid with done_o |
| fail_o | output | 1 | Sticky failure latch |

## Verification
The request is sampled on an edge. The first window appears after the next edge, and each later window one edge after the one before. done_o follows one edge after the last window, or one edge after acceptance for a refused request. The bench counts edges from the edge that takes start_i and samples at each falling edge after that. At every sample it checks both win_valid_o and done_o against the cycle number, so a window or completion that comes early or late is caught. A behavioural model built from the size rule predicts each window tuple at the cycle it is due.

// File: rtl/rws_pkg.sv
package rws_pkg;

  localparam int unsigned RWS_ADDR_W    = 40;
  localparam int unsigned RWS_WIN_CNT   = 8;
  localparam int unsigned RWS_MIN_SHIFT = 16;

  // how a region request ends in the current cycle
  typedef enum logic [1:0] {
    END_NONE  = 2'd0,
    END_OK    = 2'd1,
    END_SHORT = 2'd2,
    END_SKIP  = 2'd3
  } finish_e;

endpackage

// File: rtl/rws_msb_pick.sv
module rws_msb_pick #(
  parameter int unsigned W = 40
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] top_o
);

  // above[i] is high when any bit at position i or higher is set
  logic [W:0] above;
  assign above[W] = 1'b0;

  for (genvar i = W - 1; i >= 0; i--) begin : g_scan
    assign above[i] = above[i+1] | val_i[i];
    assign top_o[i] = val_i[i] & ~above[i+1];
  end

endmodule

// File: rtl/rws_lsb_pick.sv
module rws_lsb_pick #(
  parameter int unsigned W = 40
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] low_o
);

  assign low_o = val_i & (~val_i + {{(W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/rws_step_calc.sv
module rws_step_calc #(
  parameter int unsigned W         = 40,
  parameter int unsigned MIN_SHIFT = 16
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] phys_i,
  output logic [W-1:0] wsize_o,
  output logic [W-1:0] mask_o,
  output logic         big_o
);

  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] LOW_BITS = (ONE << MIN_SHIFT) - ONE;

  logic [W-1:0] rem_top;
  logic [W-1:0] phys_low;
  logic [W-1:0] both;

  rws_msb_pick #(.W(W)) u_rem_top (
    .val_i (rem_i),
    .top_o (rem_top)
  );

  rws_lsb_pick #(.W(W)) u_phys_low (
    .val_i (phys_i),
    .low_o (phys_low)
  );

  assign both = rem_top | phys_low;

  rws_lsb_pick #(.W(W)) u_pick_min (
    .val_i (both),
    .low_o (wsize_o)
  );

  assign mask_o = ~(wsize_o - ONE) & ~LOW_BITS;
  assign big_o  = (wsize_o != '0) && ((wsize_o & LOW_BITS) == '0);

endmodule

// File: rtl/region_window_splitter.sv
module region_window_splitter
  import rws_pkg::*;
#(
  parameter int unsigned ADDR_W    = RWS_ADDR_W,
  parameter int unsigned WIN_CNT   = RWS_WIN_CNT,
  parameter int unsigned MIN_SHIFT = RWS_MIN_SHIFT,
  localparam int unsigned IDX_W    = $clog2(WIN_CNT) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] phys_i,
  input  logic [ADDR_W-1:0] bus_i,
  input  logic [ADDR_W-1:0] size_i,
  input  logic [IDX_W-1:0]  win_idx_i,
  output logic              busy_o,
  output logic              win_valid_o,
  output logic [IDX_W-1:0]  win_num_o,
  output logic [ADDR_W-1:0] win_match_o,
  output logic [ADDR_W-1:0] win_remap_o,
  output logic [ADDR_W-1:0] win_mask_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  done_idx_o,
  output logic              err_o,
  output logic              fail_o
);

  localparam logic [IDX_W-1:0] IDX_INV  = '1;
  localparam logic [IDX_W-1:0] IDX_LIM  = IDX_W'(WIN_CNT);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
  localparam logic [ADDR_W-1:0] EN_BIT  = {{(ADDR_W-1){1'b0}}, 1'b1};

  // working state
  logic              busy_q, busy_d;
  logic              fail_q, fail_d;
  logic [ADDR_W-1:0] phys_q, phys_d;
  logic [ADDR_W-1:0] bus_q,  bus_d;
  logic [ADDR_W-1:0] rem_q,  rem_d;
  logic [IDX_W-1:0]  idx_q,  idx_d;

  // output registers
  logic              wv_q, wv_d;
  logic [IDX_W-1:0]  wnum_q;
  logic [ADDR_W-1:0] wmatch_q, wremap_q, wmask_q;
  logic              done_q, done_d;
  logic [IDX_W-1:0]  didx_q, didx_d;
  logic              err_q, err_d;

  // step datapath
  logic [ADDR_W-1:0] wsize;
  logic [ADDR_W-1:0] wmask;
  logic              big_enough;
  logic              can_emit;

  logic    load_en, step_en, fin_en;
  finish_e fin;

  rws_step_calc #(
    .W         (ADDR_W),
    .MIN_SHIFT (MIN_SHIFT)
  ) u_step (
    .rem_i   (rem_q),
    .phys_i  (phys_q),
    .wsize_o (wsize),
    .mask_o  (wmask),
    .big_o   (big_enough)
  );

  assign can_emit = (rem_q != '0) && (idx_q < IDX_LIM) && big_enough;

  // control decode
  always_comb begin
    fin     = END_NONE;
    load_en = 1'b0;
    step_en = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        if (fail_q || (win_idx_i == IDX_INV)) fin = END_SKIP;
        else                                   load_en = 1'b1;
      end
    end else if (can_emit) begin
      step_en = 1'b1;
    end else if (rem_q != '0) begin
      fin = END_SHORT;
    end else begin
      fin = END_OK;
    end
  end

  assign fin_en = (fin != END_NONE);

  // next state
  always_comb begin
    busy_d = busy_q;
    if (load_en)                                   busy_d = 1'b1;
    else if ((fin == END_OK) || (fin == END_SHORT)) busy_d = 1'b0;

    fail_d = fail_q | (fin == END_SHORT);

    phys_d = phys_q;
    bus_d  = bus_q;
    rem_d  = rem_q;
    idx_d  = idx_q;
    if (load_en) begin
      phys_d = phys_i;
      bus_d  = bus_i;
      rem_d  = size_i;
      idx_d  = win_idx_i;
    end else if (step_en) begin
      phys_d = phys_q + wsize;
      bus_d  = bus_q + wsize;
      rem_d  = rem_q - wsize;
      idx_d  = idx_q + IDX_ONE;
    end

    wv_d   = step_en;
    done_d = fin_en;
    err_d  = (fin == END_SHORT) || (fin == END_SKIP);
    didx_d = (fin == END_OK) ? idx_q : IDX_INV;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      fail_q   <= 1'b0;
      phys_q   <= '0;
      bus_q    <= '0;
      rem_q    <= '0;
      idx_q    <= '0;
      wv_q     <= 1'b0;
      wnum_q   <= '0;
      wmatch_q <= '0;
      wremap_q <= '0;
      wmask_q  <= '0;
      done_q   <= 1'b0;
      didx_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      busy_q <= busy_d;
      fail_q <= fail_d;
      wv_q   <= wv_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (load_en || step_en) begin
        phys_q <= phys_d;
        bus_q  <= bus_d;
        rem_q  <= rem_d;
        idx_q  <= idx_d;
      end
      if (step_en) begin
        wnum_q   <= idx_q;
        wmatch_q <= phys_q | EN_BIT;
        wremap_q <= bus_q;
        wmask_q  <= wmask;
      end
      if (fin_en) didx_q <= didx_d;
    end
  end

  assign busy_o      = busy_q;
  assign win_valid_o = wv_q;
  assign win_num_o   = wnum_q;
  assign win_match_o = wmatch_q;
  assign win_remap_o = wremap_q;
  assign win_mask_o  = wmask_q;
  assign done_o      = done_q;
  assign done_idx_o  = didx_q;
  assign err_o       = err_q;
  assign fail_o      = fail_q;

  // assertions
  AST_WIN_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> ((win_match_o[ADDR_W-1:1] & ~win_mask_o[ADDR_W-1:1]) == '0)); // R1

  AST_WIN_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_o && $past(win_valid_o)) |->
      (({win_match_o[ADDR_W-1:1], 1'b0} ==
        {$past(win_match_o[ADDR_W-1:1]), 1'b0} + (~$past(win_mask_o) + EN_BIT)) &&
       (win_num_o == $past(win_num_o) + IDX_ONE))); // R4

  AST_NUM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> (win_num_o < IDX_LIM)); // R5

  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> fail_o); // R6

  AST_ERR_MARKER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (done_idx_o == IDX_INV)); // R6

  AST_MATCH_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> win_match_o[0]); // R8

  AST_DONE_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, win_valid_o})); // R9

endmodule

// File: tb/region_window_splitter_tb.sv
module region_window_splitter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 40;

  typedef struct packed {
    logic [AW-1:0] phys;
    logic [AW-1:0] bus;
    logic [AW-1:0] size;
    logic [3:0]    idx;
    logic [3:0]    n;
    logic [3:0]    didx;
    logic          err;
    logic          skip;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{40'h00_0000_0000, 40'h00_4000_0000, 40'h00_0003_0000, 4'd0, 4'd2, 4'd2, 1'b0, 1'b0},
    '{40'h00_0001_0000, 40'h80_0000_0000, 40'h00_0010_0000, 4'd2, 4'd5, 4'd7, 1'b0, 1'b0},
    '{40'h00_0005_0000, 40'h00_0005_0000, 40'h00_0000_0000, 4'd7, 4'd0, 4'd7, 1'b0, 1'b0},
    '{40'h01_0000_0000, 40'h02_0000_0000, 40'h01_0000_0000, 4'd7, 4'd1, 4'd8, 1'b0, 1'b0},
    '{40'h00_0001_0000, 40'h00_0003_0000, 40'h00_0007_0000, 4'd6, 4'd2, 4'hF, 1'b1, 1'b0},
    '{40'h00_0000_0000, 40'h00_0000_0000, 40'h00_0001_0000, 4'd0, 4'd0, 4'hF, 1'b1, 1'b1}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] phys_i = '0;
  logic [AW-1:0] bus_i = '0;
  logic [AW-1:0] size_i = '0;
  logic [3:0]    win_idx_i = '0;
  logic          busy_o, win_valid_o, done_o, err_o, fail_o;
  logic [3:0]    win_num_o, done_idx_o;
  logic [AW-1:0] win_match_o, win_remap_o, win_mask_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  region_window_splitter dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .phys_i      (phys_i),
    .bus_i       (bus_i),
    .size_i      (size_i),
    .win_idx_i   (win_idx_i),
    .busy_o      (busy_o),
    .win_valid_o (win_valid_o),
    .win_num_o   (win_num_o),
    .win_match_o (win_match_o),
    .win_remap_o (win_remap_o),
    .win_mask_o  (win_mask_o),
    .done_o      (done_o),
    .done_idx_o  (done_idx_o),
    .err_o       (err_o),
    .fail_o      (fail_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // size rule written as a minimum of two candidates
  function automatic logic [AW-1:0] mdl_size(input logic [AW-1:0] rem, input logic [AW-1:0] ph);
    logic [AW-1:0] pw = '0;
    logic [AW-1:0] al = '0;
    for (int i = AW - 1; i >= 0; i--) if (rem[i] && pw == '0) pw = 40'd1 << i;
    for (int i = 0; i < AW; i++) if (ph[i] && al == '0) al = 40'd1 << i;
    if (al != '0 && al < pw) return al;
    return pw;
  endfunction

  task automatic run_region(input vec_t v, input bit hold);
    logic [AW-1:0] mp = v.phys;
    logic [AW-1:0] mb = v.bus;
    logic [AW-1:0] mr = v.size;
    logic [3:0]    mi = v.idx;
    int last = v.skip ? 0 : int'(v.n) + 1;
    @(negedge clk_i);
    start_i = 1'b1; phys_i = v.phys; bus_i = v.bus; size_i = v.size; win_idx_i = v.idx;
    for (int c = 0; c <= last; c++) begin
      @(negedge clk_i);
      if (c == 0 && hold) begin
        // second request while busy: must be dropped (R11)
        phys_i = 40'h55_5555_0000; size_i = 40'h00_0100_0000; win_idx_i = 4'd3;
      end else begin
        start_i = 1'b0;
      end
      chk(win_valid_o == (c >= 1 && c <= int'(v.n)), "R9", "window valid timing", 64'(win_valid_o), 64'(c >= 1 && c <= int'(v.n)));
      if (win_valid_o) begin
        logic [AW-1:0] sz = mdl_size(mr, mp);
        chk(win_match_o == (mp | 40'd1), "R1/R8", "match", 64'(win_match_o), 64'(mp | 40'd1));
        chk(win_remap_o == mb, "R3/R4", "remap", 64'(win_remap_o), 64'(mb));
        chk(win_mask_o == (~(sz - 40'd1) & ~40'hFFFF), "R1/R3", "mask", 64'(win_mask_o), 64'(~(sz - 40'd1) & ~40'hFFFF));
        chk(win_num_o == mi, "R4/R5", "window number", 64'(win_num_o), 64'(mi));
        mp = mp + sz; mb = mb + sz; mr = mr - sz; mi = mi + 4'd1;
      end
      chk(done_o == (c == last), "R9", "done timing", 64'(done_o), 64'(c == last));
      if (c == last) begin
        chk(done_idx_o == v.didx, v.err ? "R6/R7" : "R9", "done index", 64'(done_idx_o), 64'(v.didx));
        chk(err_o == v.err, v.err ? "R6/R7" : "R9", "err flag", 64'(err_o), 64'(v.err));
      end
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic chk_reset_state();
    chk(!busy_o && !win_valid_o && !done_o && !err_o, "R10", "idle outputs",
        64'({busy_o, win_valid_o, done_o, err_o}), 64'd0);
    chk(!fail_o, "R10", "fail clear", 64'(fail_o), 64'd0);
    chk(done_idx_o == 4'd0, "R10", "done index", 64'(done_idx_o), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk_reset_state();

    // table walk: successes, budget exhaustion (R5, R6), refusal (R7)
    for (int k = 0; k < NV; k++) run_region(VECS[k], 1'b0);
    @(negedge clk_i);
    chk(fail_o == 1'b1, "R6", "fail latched", 64'(fail_o), 64'd1);

    do_reset();
    chk_reset_state();

    // R11: start held while busy
    run_region(VECS[0], 1'b1);

    // R7: invalid start index with no failure latched
    run_region('{40'h0, 40'h0, 40'h0002_0000, 4'hF, 4'd0, 4'hF, 1'b1, 1'b1}, 1'b0);
    chk(fail_o == 1'b0, "R7", "marker index leaves latch", 64'(fail_o), 64'd0);

    // R2: first window already under the 64 KiB floor
    run_region('{40'h0000_8000, 40'h0, 40'h0002_0000, 4'd0, 4'd0, 4'hF, 1'b1, 1'b0}, 1'b0);
    @(negedge clk_i);
    chk(fail_o == 1'b1, "R2/R6", "floor stop latches fail", 64'(fail_o), 64'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule